// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the device side of a byte-wide serial EEPROM that is reached over SPI in mode 0. It holds a 4096-byte array in a synthesizable register file. The SPI pins are synchronised into a faster system clock, and edges are found from the synchronised copies. The host selects the device with `cs_n`, shifts in an 8-bit opcode, then shifts in a 16-bit address where needed, and then either clocks out array or status data or shifts in bytes to write. Array writes are gathered in a one-page buffer. They are copied into the array during a timed internal write cycle that starts when chip select is released on a byte boundary.

The write-enable latch and the write-cycle flag are kept here and shown on ports. A separate protection and status block receives one-cycle strobes for the enable, disable and status-write commands, and the status byte written by the host. It returns the six upper status bits, which the status-read command shifts out. A hold input pauses a transfer without losing its place. The serial output is given as a data bit plus an output enable, so the pad level can build the tri-state.

The controller state machine has these states. `ST_IDLE`: deselected. `ST_OPCODE`: collecting the instruction. `ST_ADDR`: collecting two address bytes. `ST_RDATA`: streaming array data. `ST_WDATA`: collecting write bytes. `ST_SOUT`: streaming the status byte. `ST_SIN`: collecting the status byte to write. `ST_DONE`: the command is complete and waits for deselect. `ST_SKIP`: the rest of the transfer is ignored.

The transitions are as follows:
- `ST_IDLE` goes to `ST_OPCODE` on a chip-select fall.
- `ST_OPCODE` goes to `ST_ADDR` for read or write, to `ST_SOUT` for status read, to `ST_SIN` for status write, to `ST_DONE` for enable or disable, and to `ST_SKIP` for an opcode that is unknown or refused.
- `ST_ADDR` goes to `ST_RDATA` or `ST_WDATA` after the second address byte.
- `ST_SIN` goes to `ST_DONE` after its byte.
- `ST_DONE` goes to `ST_SKIP` on any further SCK rise.
- Every state returns to `ST_IDLE` when chip select goes high.

Top module: `spi_eeprom_slave`

## Requirements
- R1: SI is sampled on SCK rising edges, MSB first. SO changes only after SCK falling edges, so the host reads a data byte MSB first by sampling before each rise. A READ (0x03) returns the stored bytes.
- R2: READ and WRITE (0x02) take a 16-bit address. Its upper four bits are ignored, so 0xF010 and 0x0010 name the same byte.
- R3: During READ the address moves up by one after every byte, and it wraps from 0xFFF to 0x000.
- R4: WRITE data fills a 32-byte page buffer. After the byte whose address ends in five ones, the next byte goes to the first byte of the same page.
- R5: A write cycle starts only when chip select rises with no partial byte pending and after at least one data byte. Any other rise aborts the write: nothing is stored, the write-cycle flag stays 0 and the write-enable latch is kept.
- R6: WREN (0x06) sets `wel` only when chip select rises right after its 8th bit. WRDI (0x04) clears it. Starting a write cycle or issuing a status write also clears it. WRITE and WRSR are ignored while `wel` is 0.
- R7: While chip select is high, SO is disabled. A sequence starts only after chip select is seen going high then low. A select held low through reset is not accepted.
- R8: Hold low while SCK is low pauses the transfer without reset, and SCK and SI activity is ignored. If hold falls while SCK is high, the pause begins at the next SCK fall. Raising hold while SCK is low resumes the transfer where it stopped.
- R9: `so_en` is 0 whenever the hold input is low.
- R10: `wip` is 1 for WRITE_CYCLES system clocks after a write cycle starts. During that time a READ never enables SO, and every opcode except RDSR is ignored.
- R11: RDSR (0x05) streams the status byte {prot_status[5:0], wel, wip} repeatedly: bit 1 is the write-enable latch and bit 0 is the write cycle flag.
- R12: WRSR (0x01) with `wel` set, followed by exactly one byte and then a chip-select rise, pulses `wrsr_stb` for one clock with that byte on `wrsr_data`.
- R13: An unknown opcode is ignored until chip select rises. It changes no state, pulses no strobe and never enables SO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| prot_status | input | 6 | Upper status bits from the protection block |
| so_data | output | 1 | Serial data out value |
| so_en | output | 1 | Output enable for SO; 0 means high impedance |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Internal write cycle in progress |
| wren_stb | output | 1 | One-clock pulse when WREN takes effect |
| wrdi_stb | output | 1 | One-clock pulse when WRDI takes effect |
| wrsr_stb | output | 1 | One-clock pulse when a status write takes effect |
| wrsr_data | output | 8 | Status byte written by the host |

## Verification
The bench writes four bytes across the last address of a page. A design that keeps counting past the page would put the third byte into the next page, and the read of the page start would return stale data. It aborts a write three bits into a byte and then reads back the old value. A controller that commits on any deselect would store the partial byte and raise `wip`. It reads across 0xFFF, where a missing wrap would return an unwritten location. It raises hold once with SCK low and once with SCK high, sending stray clocks in both cases. A controller that counts clocks while paused, or that misses the deferred pause, returns shifted bytes. It also tries a read, a WREN and an RDSR while the write cycle runs, a WREN with extra bits, and a select held low through reset. Each of these catches a decoder that accepts commands it should refuse.

// File: rtl/spi_eep_pkg.sv
package spi_eep_pkg;

    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_RDATA,
        ST_WDATA,
        ST_SOUT,
        ST_SIN,
        ST_DONE,
        ST_SKIP
    } eep_state_t;

endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta <= RST_VAL[i];
                q[i] <= RST_VAL[i];
            end else begin
                meta <= d[i];
                q[i] <= meta;
            end
        end
    end

endmodule

// File: rtl/eep_store.sv
module eep_store #(
    parameter int ADDR_W       = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 1024
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [7:0]                    rd_data,
    input  logic                          pb_clear,
    input  logic                          pb_we,
    input  logic [$clog2(PAGE_BYTES)-1:0] pb_idx,
    input  logic [7:0]                    pb_data,
    input  logic                          commit_go,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
    output logic                          wip
);

    localparam int PG_W  = $clog2(PAGE_BYTES);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PN_W  = ADDR_W - PG_W;
    localparam int CNT_W = $clog2(WRITE_CYCLES + 1);
    localparam logic [PG_W-1:0]  LAST_IDX = PG_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] CYC_INIT = CNT_W'(WRITE_CYCLES);

    logic [7:0]            mem  [DEPTH];
    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid;
    logic                  committing;
    logic [PG_W-1:0]       cidx;
    logic [PN_W-1:0]       page_q;
    logic [CNT_W-1:0]      busy_cnt;
    logic                  mem_we;

    assign rd_data = mem[rd_addr];
    assign wip     = (busy_cnt != '0);
    assign mem_we  = committing && pvalid[cidx];

    always_ff @(posedge clk) begin
        if (pb_we) pbuf[pb_idx] <= pb_data;
    end

    always_ff @(posedge clk) begin
        if (mem_we) mem[{page_q, cidx}] <= pbuf[cidx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pvalid <= '0;
        end else if (pb_clear) begin
            pvalid <= '0;
        end else if (pb_we) begin
            pvalid[pb_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            committing <= 1'b0;
            cidx       <= '0;
            page_q     <= '0;
            busy_cnt   <= '0;
        end else if (commit_go && !wip) begin
            committing <= 1'b1;
            cidx       <= '0;
            page_q     <= commit_page;
            busy_cnt   <= CYC_INIT;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (committing) begin
                cidx <= cidx + 1'b1;
                if (cidx == LAST_IDX) committing <= 1'b0;
            end
        end
    end

    // R5
    commit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wip);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(commit_go));

    initial begin
        if (WRITE_CYCLES < PAGE_BYTES) $error("WRITE_CYCLES must cover one page copy");
    end

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import spi_eep_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int PAGE_BYTES = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cs_s,
    input  logic                          sck_s,
    input  logic                          si_s,
    input  logic                          hold_s,
    input  logic                          wip,
    input  logic [5:0]                    prot_status,
    input  logic [7:0]                    rd_data,
    output logic [ADDR_W-1:0]             rd_addr,
    output logic                          pb_clear,
    output logic                          pb_we,
    output logic [$clog2(PAGE_BYTES)-1:0] pb_idx,
    output logic [7:0]                    pb_data,
    output logic                          commit_go,
    output logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
    output logic                          so_data,
    output logic                          so_en,
    output logic                          wel,
    output logic                          wren_stb,
    output logic                          wrdi_stb,
    output logic                          wrsr_stb,
    output logic [7:0]                    wrsr_data
);

    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam logic [PG_W-1:0] PG_LAST = '1;

    eep_state_t        state, nxt;
    logic              cs_q, sck_q, paused;
    logic              cs_rise, cs_fall, sck_rise, sck_fall, byte_end;
    logic [2:0]        bitcnt;
    logic [7:0]        sh, rx_byte, op, tx, sin_q, stat_byte;
    logic [ADDR_W-1:0] addr;
    logic              addr_hi, got_byte, so_q;

    assign cs_rise   = cs_s && !cs_q;
    assign cs_fall   = !cs_s && cs_q;
    assign sck_rise  = sck_s && !sck_q && !paused;
    assign sck_fall  = !sck_s && sck_q && !paused;
    assign rx_byte   = {sh[6:0], si_s};
    assign byte_end  = sck_rise && (bitcnt == 3'd7);
    assign stat_byte = {prot_status, wel, wip};

    // next state
    always_comb begin
        nxt = state;
        if (cs_s) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:   if (cs_fall) nxt = ST_OPCODE;
                ST_OPCODE: if (byte_end) begin
                    if (rx_byte == OP_READ)       nxt = wip ? ST_SKIP : ST_ADDR;
                    else if (rx_byte == OP_WRITE) nxt = (wip || !wel) ? ST_SKIP : ST_ADDR;
                    else if (rx_byte == OP_WREN || rx_byte == OP_WRDI)
                                                  nxt = wip ? ST_SKIP : ST_DONE;
                    else if (rx_byte == OP_RDSR)  nxt = ST_SOUT;
                    else if (rx_byte == OP_WRSR)  nxt = (wip || !wel) ? ST_SKIP : ST_SIN;
                    else                          nxt = ST_SKIP;
                end
                ST_ADDR:   if (byte_end && addr_hi) nxt = (op == OP_READ) ? ST_RDATA : ST_WDATA;
                ST_SIN:    if (byte_end) nxt = ST_DONE;
                ST_DONE:   if (sck_rise) nxt = ST_SKIP;
                ST_RDATA, ST_WDATA, ST_SOUT, ST_SKIP: nxt = state;
                default:   nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // outputs toward the store and the pins
    always_comb begin
        rd_addr     = (state == ST_ADDR) ? {addr[ADDR_W-1:8], rx_byte} : addr + 1'b1;
        pb_clear    = byte_end && (state == ST_ADDR) && addr_hi && (op == OP_WRITE);
        pb_we       = byte_end && (state == ST_WDATA);
        pb_idx      = addr[PG_W-1:0];
        pb_data     = rx_byte;
        commit_go   = cs_rise && (state == ST_WDATA) && (bitcnt == 3'd0) && got_byte;
        commit_page = addr[ADDR_W-1:PG_W];
        so_data     = so_q;
        so_en       = ((state == ST_RDATA) || (state == ST_SOUT)) && !cs_s && hold_s && !paused;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q      <= 1'b0;
            sck_q     <= 1'b0;
            paused    <= 1'b0;
            bitcnt    <= '0;
            sh        <= '0;
            op        <= '0;
            tx        <= '0;
            sin_q     <= '0;
            addr      <= '0;
            addr_hi   <= 1'b0;
            got_byte  <= 1'b0;
            so_q      <= 1'b0;
            wel       <= 1'b0;
            wren_stb  <= 1'b0;
            wrdi_stb  <= 1'b0;
            wrsr_stb  <= 1'b0;
            wrsr_data <= '0;
        end else begin
            cs_q     <= cs_s;
            sck_q    <= sck_s;
            wren_stb <= 1'b0;
            wrdi_stb <= 1'b0;
            wrsr_stb <= 1'b0;

            if (cs_s)        paused <= 1'b0;
            else if (!sck_s) paused <= !hold_s;

            if (cs_rise && state == ST_DONE) begin
                if (op == OP_WREN) begin
                    wel      <= 1'b1;
                    wren_stb <= 1'b1;
                end else if (op == OP_WRDI) begin
                    wel      <= 1'b0;
                    wrdi_stb <= 1'b1;
                end else if (op == OP_WRSR) begin
                    wel       <= 1'b0;
                    wrsr_stb  <= 1'b1;
                    wrsr_data <= sin_q;
                end
            end
            if (commit_go) wel <= 1'b0;

            if (cs_s) begin
                bitcnt   <= '0;
                addr_hi  <= 1'b0;
                got_byte <= 1'b0;
            end else begin
                if (sck_rise && state != ST_IDLE) begin
                    sh     <= rx_byte;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == 3'd7) begin
                        unique case (state)
                            ST_OPCODE: begin
                                op <= rx_byte;
                                tx <= stat_byte;
                            end
                            ST_ADDR: begin
                                if (!addr_hi) begin
                                    addr[ADDR_W-1:8] <= rx_byte[ADDR_W-9:0];
                                    addr_hi          <= 1'b1;
                                end else begin
                                    addr[7:0] <= rx_byte;
                                    tx        <= rd_data;
                                end
                            end
                            ST_RDATA: begin
                                addr <= addr + 1'b1;
                                tx   <= rd_data;
                            end
                            ST_WDATA: begin
                                addr[PG_W-1:0] <= addr[PG_W-1:0] + 1'b1;
                                got_byte       <= 1'b1;
                            end
                            ST_SOUT: tx    <= stat_byte;
                            ST_SIN:  sin_q <= rx_byte;
                            ST_IDLE, ST_DONE, ST_SKIP: ;
                            default: ;
                        endcase
                    end
                end
                if (sck_fall && (state == ST_RDATA || state == ST_SOUT)) begin
                    so_q <= tx[~bitcnt];
                end
            end
        end
    end

    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (state == ST_IDLE));

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && !cs_s) |=> $stable(bitcnt));

    // R10
    busy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wip |-> (state != ST_RDATA));

    // R6
    wel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |-> wel);

    // R4
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_we && addr[PG_W-1:0] == PG_LAST) |=> (addr[PG_W-1:0] == '0));

endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
    parameter int ADDR_W       = 12,
    parameter int PAGE_BYTES   = 32,
    parameter int WRITE_CYCLES = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    input  logic       hold_n,
    input  logic [5:0] prot_status,
    output logic       so_data,
    output logic       so_en,
    output logic       wel,
    output logic       wip,
    output logic       wren_stb,
    output logic       wrdi_stb,
    output logic       wrsr_stb,
    output logic [7:0] wrsr_data
);

    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int PN_W = ADDR_W - PG_W;

    logic [3:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data, pb_data;
    logic              pb_clear, pb_we, commit_go;
    logic [PG_W-1:0]   pb_idx;
    logic [PN_W-1:0]   commit_page;

    // bit 3: chip select, 2: clock, 1: data, 0: hold
    eep_sync #(.W(4), .RST_VAL(4'b0001)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sck, si, hold_n}),
        .q     (pins_s)
    );

    eep_ctrl #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_s        (pins_s[3]),
        .sck_s       (pins_s[2]),
        .si_s        (pins_s[1]),
        .hold_s      (pins_s[0]),
        .wip         (wip),
        .prot_status (prot_status),
        .rd_data     (rd_data),
        .rd_addr     (rd_addr),
        .pb_clear    (pb_clear),
        .pb_we       (pb_we),
        .pb_idx      (pb_idx),
        .pb_data     (pb_data),
        .commit_go   (commit_go),
        .commit_page (commit_page),
        .so_data     (so_data),
        .so_en       (so_en),
        .wel         (wel),
        .wren_stb    (wren_stb),
        .wrdi_stb    (wrdi_stb),
        .wrsr_stb    (wrsr_stb),
        .wrsr_data   (wrsr_data)
    );

    eep_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WRITE_CYCLES(WRITE_CYCLES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .pb_clear    (pb_clear),
        .pb_we       (pb_we),
        .pb_idx      (pb_idx),
        .pb_data     (pb_data),
        .commit_go   (commit_go),
        .commit_page (commit_page),
        .wip         (wip)
    );

endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b0;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       hold_n = 1'b1;
    logic [5:0] prot_status = 6'b101010;
    logic       so_data, so_en, wel, wip, wren_stb, wrdi_stb, wrsr_stb;
    logic [7:0] wrsr_data;

    int n_checks = 0;
    int n_fails  = 0;
    int n_wren = 0, n_wrdi = 0, n_wrsr = 0;
    logic [7:0] rbuf [8];
    logic [7:0] wbuf [8];
    logic       en_any;

    spi_eeprom_slave dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .prot_status(prot_status), .so_data(so_data), .so_en(so_en), .wel(wel), .wip(wip),
        .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb), .wrsr_data(wrsr_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (wren_stb) n_wren++;
        if (wrdi_stb) n_wrdi++;
        if (wrsr_stb) n_wrsr++;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_io(input logic b, output logic r);
        si = b;
        tick(HALF);
        r = so_data;
        if (so_en) en_any = 1'b1;
        sck = 1'b1;
        tick(HALF);
        sck = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_io(tx[i], r);
            rx[i] = r;
        end
    endtask

    task automatic sel();
        en_any = 1'b0;
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic desel();
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic cmd1(input logic [7:0] opc);
        logic [7:0] d;
        sel();
        xfer(opc, d);
        desel();
    endtask

    task automatic wait_idle();
        while (wip) tick(1);
        tick(2);
    endtask

    task automatic do_write(input logic [15:0] a, input int n);
        logic [7:0] d;
        sel();
        xfer(8'h02, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(wbuf[i], d);
        desel();
    endtask

    task automatic do_read(input logic [15:0] a, input int n);
        logic [7:0] d;
        sel();
        xfer(8'h03, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int i = 0; i < n; i++) xfer(8'h00, rbuf[i]);
        desel();
    endtask

    task automatic t_powerup();
        logic [7:0] d;
        // select low through reset: RDSR must not be accepted (R7)
        en_any = 1'b0;
        xfer(8'h05, d);
        xfer(8'h00, d);
        check("R7 held select not accepted", en_any, 1'b0);
        cs_n = 1'b1;
        tick(8);
        check("R7 so disabled while deselected", so_en, 1'b0);
    endtask

    task automatic t_reset();
        check("R6 wel after reset", wel, 1'b0);
        check("R10 wip after reset", wip, 1'b0);
        check("R7 so_en after reset", so_en, 1'b0);
    endtask

    task automatic t_basic_write_read();
        logic [7:0] d;
        cmd1(8'h06);
        check("R6 wel set by WREN", wel, 1'b1);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        do_write(16'h0010, 3);
        check("R5 wip after commit", wip, 1'b1);
        check("R6 wel cleared by commit", wel, 1'b0);
        // R10: read refused while busy
        do_read(16'h0010, 1);
        check("R10 read refused while busy", en_any, 1'b0);
        cmd1(8'h06);
        check("R10 WREN ignored while busy", wel, 1'b0);
        sel();
        xfer(8'h05, d);
        xfer(8'h00, d);
        desel();
        check("R11 RDSR while busy", d, 8'hA9);
        wait_idle();
        do_read(16'h0010, 3);
        check("R1 read byte 0", rbuf[0], 8'h11);
        check("R1 read byte 1", rbuf[1], 8'h22);
        check("R1 read byte 2", rbuf[2], 8'h33);
        do_read(16'hF010, 1);
        check("R2 upper address bits ignored", rbuf[0], 8'h11);
    endtask

    task automatic t_no_wel();
        wbuf[0] = 8'h99;
        do_write(16'h0010, 1);
        check("R6 write without wel no cycle", wip, 1'b0);
        do_read(16'h0010, 1);
        check("R6 write without wel no change", rbuf[0], 8'h11);
    endtask

    task automatic t_page_wrap();
        cmd1(8'h06);
        wbuf[0] = 8'hA0; wbuf[1] = 8'hA1; wbuf[2] = 8'hA2; wbuf[3] = 8'hA3;
        do_write(16'h005E, 4);
        wait_idle();
        do_read(16'h0040, 2);
        check("R4 wrap to page start byte 0", rbuf[0], 8'hA2);
        check("R4 wrap to page start byte 1", rbuf[1], 8'hA3);
        do_read(16'h005E, 2);
        check("R4 page end byte 0", rbuf[0], 8'hA0);
        check("R4 page end byte 1", rbuf[1], 8'hA1);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        logic r;
        cmd1(8'h06);
        wbuf[0] = 8'h77;
        do_write(16'h0100, 1);
        wait_idle();
        cmd1(8'h06);
        sel();
        xfer(8'h02, d);
        xfer(8'h01, d);
        xfer(8'h00, d);
        xfer(8'h55, d);
        bit_io(1'b1, r);
        bit_io(1'b0, r);
        bit_io(1'b1, r);
        desel();
        check("R5 partial byte no cycle", wip, 1'b0);
        check("R5 abort keeps wel", wel, 1'b1);
        do_read(16'h0100, 1);
        check("R5 aborted data not stored", rbuf[0], 8'h77);
        cmd1(8'h04);
        check("R6 WRDI clears wel", wel, 1'b0);
    endtask

    task automatic t_read_wrap();
        cmd1(8'h06);
        wbuf[0] = 8'hC3;
        do_write(16'h0FFF, 1);
        wait_idle();
        cmd1(8'h06);
        wbuf[0] = 8'h3C;
        do_write(16'h0000, 1);
        wait_idle();
        do_read(16'h0FFF, 2);
        check("R3 last address", rbuf[0], 8'hC3);
        check("R3 wrap to zero", rbuf[1], 8'h3C);
    endtask

    task automatic t_status();
        logic [7:0] d0, d1;
        int w0;
        cmd1(8'h06);
        sel();
        xfer(8'h05, d0);
        xfer(8'h00, d0);
        xfer(8'h00, d1);
        desel();
        check("R11 status first", d0, 8'hAA);
        check("R11 status repeated", d1, 8'hAA);
        w0 = n_wrsr;
        sel();
        xfer(8'h01, d0);
        xfer(8'h8C, d0);
        desel();
        check("R12 wrsr strobe", n_wrsr - w0, 1);
        check("R12 wrsr data", wrsr_data, 8'h8C);
        check("R6 wrsr clears wel", wel, 1'b0);
        sel();
        xfer(8'h01, d0);
        xfer(8'h44, d0);
        desel();
        check("R6 wrsr ignored without wel", n_wrsr - w0, 1);
    endtask

    task automatic t_wren_extra();
        logic [7:0] d;
        logic r;
        int w0;
        w0 = n_wren;
        sel();
        xfer(8'h06, d);
        bit_io(1'b0, r);
        bit_io(1'b0, r);
        desel();
        check("R6 WREN with extra bits", wel, 1'b0);
        check("R6 WREN extra no strobe", n_wren - w0, 0);
    endtask

    task automatic t_unknown();
        logic [7:0] d;
        int s0;
        cmd1(8'h06);
        s0 = n_wren + n_wrdi + n_wrsr;
        sel();
        xfer(8'hFF, d);
        xfer(8'h04, d);
        xfer(8'h00, d);
        desel();
        check("R13 unknown opcode so off", en_any, 1'b0);
        check("R13 unknown opcode no strobe", n_wren + n_wrdi + n_wrsr - s0, 0);
        check("R13 unknown opcode wel kept", wel, 1'b1);
        cmd1(8'h04);
    endtask

    task automatic t_hold();
        logic [7:0] d, b2, b3;
        logic r;
        sel();
        xfer(8'h03, d);
        xfer(8'h00, d);
        xfer(8'h10, d);
        xfer(8'h00, rbuf[0]);
        // pause with SCK low
        hold_n = 1'b0;
        tick(6);
        check("R9 so off while hold low", so_en, 1'b0);
        for (int i = 0; i < 3; i++) begin
            si = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        hold_n = 1'b1;
        tick(HALF);
        xfer(8'h00, b2);
        // pause requested while SCK is high
        si = 1'b0;
        tick(HALF);
        b3[7] = so_data;
        sck = 1'b1;
        tick(2);
        hold_n = 1'b0;
        tick(HALF);
        sck = 1'b0;
        tick(HALF);
        for (int i = 0; i < 2; i++) begin
            sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF);
        end
        check("R9 so off during deferred pause", so_en, 1'b0);
        hold_n = 1'b1;
        tick(HALF);
        for (int i = 6; i >= 0; i--) begin
            bit_io(1'b0, r);
            b3[i] = r;
        end
        desel();
        check("R8 first byte before hold", rbuf[0], 8'h11);
        check("R8 byte after hold with SCK low", b2, 8'h22);
        check("R8 byte after hold with SCK high", b3, 8'h33);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_powerup();
        t_basic_write_read();
        t_no_wel();
        t_page_wrap();
        t_abort();
        t_read_wrap();
        t_status();
        t_wren_extra();
        t_unknown();
        t_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule